// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Ratio Controller

This block is the digital side of a programmable integer frequency divider that wraps a divide-by-4/5 prescaler. It takes a division ratio N and breaks it into a pulse count P (the upper bits of N) and a swallow count S (the two low bits of N), so that N = 4·P + S. Over one output period the prescaler produces P pulses. The first S of them are long (divide-by-5) and the remaining P−S are short (divide-by-4). Each output pulse therefore spans exactly N input cycles.

The model is synchronous to the fast input clock. The prescaler output reaches it as a one-cycle strobe `pre_tick`, and it returns the modulus select `mod_sel`. The strobe marks the edge where the prescaler begins a new segment, and `mod_sel` at that edge sets the length of that segment. A fresh ratio is taken from `ratio_in` once per output period, at the strobe that opens the last segment of the running period. Both counters reload on that strobe, so a sigma-delta modulator may change `ratio_in` every period without disturbing the period already under way. A ratio below the minimum is raised to the minimum, and `ratio_low` then flags that period.

The controller is a three-state machine:
- ST_IDLE is the state after reset.
- ST_SWALLOW means the next segment is divide-by-5.
- ST_PLAIN means the next segment is divide-by-4.

The transitions are:
- "first load": ST_IDLE goes to ST_SWALLOW or ST_PLAIN on the first strobe.
- "swallow done": ST_SWALLOW goes to ST_PLAIN when the last long segment starts.
- "reload": from either counting state to ST_SWALLOW when the new S is nonzero, otherwise to ST_PLAIN, at the terminal strobe.
- "hold": any counting state stays where it is when no strobe arrives.

Top module: `psd_divider_ctrl`

## Requirements
- R1: While reset is held, `mod_sel`, `div_out` and `ratio_low` are all 0.
- R2: For every ratio N from MIN_RATIO (16) to 2^(PC_W+2)−1, consecutive `div_out` pulses are exactly N clock cycles apart, with no gaps in that range.
- R3: `div_out` is high for one cycle, in the cycle right after the `pre_tick` strobe that opens a period.
- R4: One output period contains exactly P = N>>2 strobes. `mod_sel` is 1 at the first S = N mod 4 of them (divide-by-5) and 0 at the rest (divide-by-4).
- R5: `ratio_in` is sampled only at the strobe that starts the final segment of a period. A change made after that strobe does not alter the following period.
- R6: A requested ratio below MIN_RATIO is executed as MIN_RATIO. `ratio_low` is 1 from the sampling strobe of that period until the next sampling strobe, and no output period is ever shorter than MIN_RATIO.
- R7: For a requested ratio of MIN_RATIO or more, `ratio_low` is 0 over that period.
- R8: The largest ratio, all ones in `ratio_in`, divides correctly. So does the smallest legal ratio, 16.
- R9: `mod_sel` and `ratio_low` change only in the cycle after a `pre_tick` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input (fast) clock that the prescaler divides |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_tick | input | 1 | One-cycle strobe at the start of each prescaler segment |
| ratio_in | input | PC_W+2 | Requested division ratio N |
| mod_sel | output | 1 | 1 selects divide-by-5 for the segment starting at this strobe, 0 selects divide-by-4 |
| div_out | output | 1 | One-cycle output pulse per N clock cycles |
| ratio_low | output | 1 | Current period's request was below MIN_RATIO and was clamped |

## Verification
The bench uses a 6-bit pulse counter and sweeps every ratio from 16 to 255 in rising order. Each measured interval separates errors in the 4·P + S arithmetic, and the per-period count of long and short segments separates a wrong P from a wrong S even when their sum happens to match.

A random run then changes the ratio every period, including requests below 16. This tells correct reload timing apart from a ratio applied one period early or late, and shows whether clamping and its flag follow the period they belong to. A third pattern changes `ratio_in` again inside the final segment, after the sampling strobe. It tells a controller that samples only at the terminal strobe apart from one that keeps following its input.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_PLAIN   = 2'd2
    } psd_state_e;

    // two low ratio bits address the 4/5 prescaler swallow range 0..3
    localparam int SC_W = 2;

endpackage

// File: rtl/psd_ratio_split.sv
module psd_ratio_split #(
    parameter int PC_W      = 17,
    parameter int SC_W      = 2,
    parameter int MIN_RATIO = 16
) (
    input  logic [PC_W+SC_W-1:0] ratio_in,
    output logic [PC_W-1:0]      p_load,
    output logic [SC_W-1:0]      s_load,
    output logic                 s_nonzero,
    output logic                 too_low
);
    localparam int N_W = PC_W + SC_W;
    localparam logic [N_W-1:0] MIN_V = N_W'(MIN_RATIO);

    logic [N_W-1:0] eff;

    always_comb begin
        too_low   = (ratio_in < MIN_V);
        eff       = too_low ? MIN_V : ratio_in;
        p_load    = eff[N_W-1:SC_W];
        s_load    = eff[SC_W-1:0];
        s_nonzero = (s_load != '0);
    end

endmodule

// File: rtl/psd_down_counter.sv
module psd_down_counter #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_one
);
    logic [W-1:0] value;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (dec && (value != '0)) begin
            value <= value - W'(1);
        end
    end

    assign is_one = (value == W'(1));

endmodule

// File: rtl/psd_ctrl_fsm.sv
module psd_ctrl_fsm
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pre_tick,
    input  logic pc_last,
    input  logic sc_last,
    input  logic s_nonzero,
    input  logic too_low,
    output logic load,
    output logic pc_dec,
    output logic sc_dec,
    output logic mod_sel,
    output logic div_out,
    output logic ratio_low
);
    psd_state_e state, state_nx;
    psd_state_e reload_state;
    logic       fresh;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        reload_state = s_nonzero ? ST_SWALLOW : ST_PLAIN;
        state_nx     = state;
        unique case (state)
            ST_IDLE: begin
                if (pre_tick) state_nx = reload_state;          // first load
            end
            ST_SWALLOW: begin
                if (pre_tick) begin
                    if (pc_last)      state_nx = reload_state;  // reload
                    else if (sc_last) state_nx = ST_PLAIN;      // swallow done
                end
            end
            ST_PLAIN: begin
                if (pre_tick && pc_last) state_nx = reload_state; // reload
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // counter controls and modulus select
    always_comb begin
        load    = pre_tick && ((state == ST_IDLE) || pc_last);
        pc_dec  = pre_tick && !load;
        sc_dec  = pre_tick && !load && (state == ST_SWALLOW);
        mod_sel = (state == ST_SWALLOW);
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh     <= 1'b0;
            div_out   <= 1'b0;
            ratio_low <= 1'b0;
        end else begin
            div_out <= pre_tick && fresh;
            if (load) begin
                fresh     <= 1'b1;
                ratio_low <= too_low;
            end else if (pre_tick) begin
                fresh <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/psd_divider_ctrl.sv
module psd_divider_ctrl
    import psd_pkg::*;
#(
    parameter int PC_W      = 17,
    parameter int MIN_RATIO = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pre_tick,
    input  logic [PC_W+SC_W-1:0] ratio_in,
    output logic                 mod_sel,
    output logic                 div_out,
    output logic                 ratio_low
);
    logic [PC_W-1:0] p_load;
    logic [SC_W-1:0] s_load;
    logic s_nonzero, too_low;
    logic load, pc_dec, sc_dec, pc_last, sc_last;

    psd_ratio_split #(
        .PC_W(PC_W), .SC_W(SC_W), .MIN_RATIO(MIN_RATIO)
    ) i_split (
        .ratio_in (ratio_in),
        .p_load   (p_load),
        .s_load   (s_load),
        .s_nonzero(s_nonzero),
        .too_low  (too_low)
    );

    psd_down_counter #(.W(PC_W)) i_pulse_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(p_load),
        .dec     (pc_dec),
        .is_one  (pc_last)
    );

    psd_down_counter #(.W(SC_W)) i_swallow_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(s_load),
        .dec     (sc_dec),
        .is_one  (sc_last)
    );

    psd_ctrl_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_tick (pre_tick),
        .pc_last  (pc_last),
        .sc_last  (sc_last),
        .s_nonzero(s_nonzero),
        .too_low  (too_low),
        .load     (load),
        .pc_dec   (pc_dec),
        .sc_dec   (sc_dec),
        .mod_sel  (mod_sel),
        .div_out  (div_out),
        .ratio_low(ratio_low)
    );

endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
    parameter int MIN_RATIO = 16
) (
    input logic clk,
    input logic rst_n,
    input logic pre_tick,
    input logic mod_sel,
    input logic div_out,
    input logic ratio_low
);
    logic [31:0] gap;
    logic        seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else begin
            if (div_out) begin
                gap  <= 32'd1;
                seen <= 1'b1;
            end else if (gap != 32'hFFFF_FFFF) begin
                gap <= gap + 32'd1;
            end
        end
    end

    AST_OUT_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |-> $past(pre_tick)); // R3

    AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out); // R3

    AST_MODSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_tick |=> $stable(mod_sel)); // R9

    AST_LOWFLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_tick |=> $stable(ratio_low)); // R9

    AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (div_out && seen) |-> (gap >= 32'(MIN_RATIO))); // R6

endmodule

bind psd_divider_ctrl psd_divider_chk #(.MIN_RATIO(MIN_RATIO)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_tick (pre_tick),
    .mod_sel  (mod_sel),
    .div_out  (div_out),
    .ratio_low(ratio_low)
);

// File: tb/test_psd_divider_ctrl.sv
module test_psd_divider_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 6;
    localparam int N_W        = PC_W + 2;
    localparam int MIN_R      = 16;
    localparam int MAX_R      = (1 << N_W) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pre_tick;
    logic [N_W-1:0] ratio_in;
    logic           mod_sel, div_out, ratio_low;
    logic [2:0]     pcnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int tk_c, sw_c, last_ms, prev_ms, prev_tick;
    int m_len, m_tk, m_sw, m_low;
    int cur_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    // 4/5 prescaler model: segment length is 5 when mod_sel is high at its strobe
    assign pre_tick = rst_n && (pcnt == 3'd0);
    always @(posedge clk) begin
        if (!rst_n)            pcnt <= 3'd0;
        else if (pcnt == 3'd0) pcnt <= mod_sel ? 3'd4 : 3'd3;
        else                   pcnt <= pcnt - 3'd1;
    end

    psd_divider_ctrl #(.PC_W(PC_W), .MIN_RATIO(MIN_R)) i_psd_divider_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_tick (pre_tick),
        .ratio_in (ratio_in),
        .mod_sel  (mod_sel),
        .div_out  (div_out),
        .ratio_low(ratio_low)
    );

    function automatic int eff(int n);
        return (n < MIN_R) ? MIN_R : n;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // run until the next div_out; optionally rewrite ratio_in after the sampling strobe
    task automatic wait_out(int trig, int late_v);
        int  len = 0;
        bit  pend = 1'b0;
        bit  got = 1'b0;
        while (!got) begin
            @(negedge clk);
            len++;
            if (len > 4000) begin
                check("watchdog", 1, 0);
                m_len = -1; m_tk = -1; m_sw = -1; m_low = -1;
                got = 1'b1;
            end else begin
                if (pend) begin
                    ratio_in = N_W'(late_v);
                    pend = 1'b0;
                end
                if (len == 1) check("R3 pulse width", int'(div_out), 0);
                if ((int'(mod_sel) != prev_ms) && (prev_tick == 0))
                    check("R9 mod_sel moved without strobe", int'(mod_sel), prev_ms);
                if (div_out) begin
                    check("R3 strobe before pulse", prev_tick, 1);
                    m_len = len; m_tk = tk_c - 1; m_sw = sw_c - last_ms;
                    m_low = int'(ratio_low);
                    tk_c = 1; sw_c = last_ms;
                    got = 1'b1;
                end else if (pre_tick) begin
                    tk_c++;
                    sw_c += int'(mod_sel);
                    last_ms = int'(mod_sel);
                    if ((trig > 0) && (tk_c == trig)) pend = 1'b1;
                end
                prev_ms   = int'(mod_sel);
                prev_tick = int'(pre_tick);
            end
        end
    endtask

    // one output period: request nxt for the following period, check the current one
    task automatic period(int nxt, bit late_en, int late_v);
        int e = eff(cur_n);
        string tag;
        ratio_in = N_W'(nxt);
        wait_out(late_en ? (e >> 2) : 0, late_v);
        if (late_en)                          tag = "R5 late change ignored";
        else if (e == MAX_R || e == MIN_R)    tag = "R8 extreme ratio";
        else                                  tag = "R2 interval";
        check(tag, m_len, e);
        check("R4 pulse segments", m_tk, e >> 2);
        check("R4 swallow segments", m_sw, e & 3);
        if (nxt < MIN_R) check("R6 clamp flag", m_low, 1);
        else             check("R7 flag clear", m_low, 0);
        cur_n = nxt;
    endtask

    initial begin
        ratio_in = N_W'(20);
        tk_c = 0; sw_c = 0; last_ms = 0; prev_ms = 0; prev_tick = 0;
        repeat (3) @(negedge clk);
        check("R1 mod_sel in reset", int'(mod_sel), 0);
        check("R1 div_out in reset", int'(div_out), 0);
        check("R1 ratio_low in reset", int'(ratio_low), 0);
        rst_n = 1'b1;
        wait_out(0, 0);
        check("R7 first flag", m_low, 0);
        cur_n = 20;
        // exhaustive rising sweep of the legal range
        for (int n = MIN_R; n <= MAX_R; n++) period(n, 1'b0, 0);
        // requests below the minimum
        for (int n = 0; n < MIN_R; n += 3) period(n, 1'b0, 0);
        period(MIN_R, 1'b0, 0);
        period(MAX_R, 1'b0, 0);
        // per-period dithering
        for (int k = 0; k < 200; k++) period(int'($urandom_range(0, MAX_R)), 1'b0, 0);
        // changes made after the sampling strobe
        for (int k = 0; k < 12; k++) begin
            period(40 + 17 * k, 1'b0, 0);
            period(25 + 9 * k, 1'b1, (k % 2 == 0) ? 3 : MAX_R);
        end
        period(20, 1'b0, 0);
        period(20, 1'b0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule